// File: doc/BRIEF.md
# Programmable Interval Timer with Reload

This block is an 8-bit programmable timer for a small handheld-class system. A free-running 16-bit divider advances on every clock. One of four divider taps, chosen by a 2-bit rate field and gated by an enable bit, drives the counter. The counter advances each time that gated tap goes from high to low. When the counter steps past 0xFF it takes the value of the modulo register, enters a short reload sequence, and sends a single-cycle interrupt request pulse to the interrupt controller.

Software reaches four registers through a small bus port: the divider's upper byte, the counter, the modulo value and the control register. A write of any value to the divider address clears all 16 divider bits. The counter advances on the falling edge of the gated tap and not on its level, so a register write that pulls the gated tap low also advances the counter. Both a control write and a divider clear can do this. An overflow started by a control write sends its interrupt one cycle earlier than any other overflow.

Top module: `prog_timer`

## Requirements
- R1: After reset the counter and modulo registers read 0x00, the control register reads 0xF8, the divider's upper byte reads 0x00 and `irq_o` is low.
- R2: Address 0 reads divider bits [15:8]. Address 1 is the counter, address 2 the modulo register and address 3 the control register. Written values read back unchanged. At address 3 only bits [2:0] are stored and bits [7:3] read as 1.
- R3: The divider increments by one on every clock. A write to address 0 clears all 16 bits whatever the data.
- R4: Control bit 2 enables the timer. Bits [1:0] select the divider tap: 00 selects bit 9 (period 1024), 01 bit 3 (period 16), 10 bit 5 (period 64) and 11 bit 7 (period 256). The counter increments on the clock edge that closes the first cycle in which the gated tap is low after being high. It does not change otherwise, except by a bus write.
- R5: An increment from 0xFF loads the modulo value into the counter on that same edge.
- R6: An overflow not started by a control write raises `irq_o` for exactly one cycle, two cycles after the edge that loaded the modulo value.
- R7: A control write that turns the gated tap from high to low advances the counter, whether it clears the enable or selects a tap that is low. A control write while the gated tap is already low does not advance the counter.
- R8: An overflow caused by the increment from a control write raises `irq_o` for one cycle, one cycle after the loading edge.
- R9: A divider clear while the gated tap is high advances the counter. An overflow caused this way uses the two-cycle timing of R6, even when the previous overflow came from a control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 2 | Register select: 0 divider, 1 counter, 2 modulo, 3 control |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Single-cycle timer interrupt request |

## Verification
Two events can coincide on the same edge: a control write and a counter overflow. That happens when the write pulls the gated tap low while the counter holds 0xFF. The bench sets this up by disabling the timer in the middle of a tap-high window with the counter at 0xFF, and it checks that the pulse arrives one cycle after the reload edge. It then makes a divider clear overflow the counter and checks that the pulse is back on the later cycle. This shows the early timing did not persist from the previous overflow.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam logic [1:0] A_DIV  = 2'd0;
  localparam logic [1:0] A_CNT  = 2'd1;
  localparam logic [1:0] A_MOD  = 2'd2;
  localparam logic [1:0] A_CTRL = 2'd3;

  typedef enum logic [1:0] {
    RL_IDLE    = 2'd0,
    RL_LOADING = 2'd1,
    RL_DONE    = 2'd2
  } rl_state_e;

  // Divider bit index chosen by each rate-select code.
  function automatic int unsigned tap_bit(input logic [1:0] rate);
    case (rate)
      2'd0:    tap_bit = 9;
      2'd1:    tap_bit = 3;
      2'd2:    tap_bit = 5;
      default: tap_bit = 7;
    endcase
  endfunction

endpackage

// File: rtl/tmr_divider.sv
module tmr_divider #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  output logic [DIV_W-1:0] div_o
);

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] div_d;

  always_comb begin
    if (clr_i) div_d = '0;
    else       div_d = div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  assign div_o = div_q;

endmodule

// File: rtl/tmr_edge.sv
module tmr_edge #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_i,
  input  logic             en_i,
  input  logic [1:0]       rate_i,
  input  logic             ctrl_wr_i,
  output logic             inc_o,
  output logic             glitch_o,
  output logic             lvl_q_o
);

  localparam int N_TAPS = 4;

  logic [N_TAPS-1:0] taps;
  logic              lvl;
  logic              lvl_q;
  logic              lvl_d;
  logic              cw_q;
  logic              cw_d;

  // One divider tap per rate code
  for (genvar i = 0; i < N_TAPS; i++) begin : g_tap
    localparam int unsigned TB = tmr_pkg::tap_bit(2'(i));
    assign taps[i] = div_i[TB];
  end

  always_comb begin
    lvl   = taps[rate_i] & en_i;
    lvl_d = lvl;
    cw_d  = ctrl_wr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      cw_q  <= 1'b0;
    end else begin
      lvl_q <= lvl_d;
      cw_q  <= cw_d;
    end
  end

  assign inc_o    = lvl_q & ~lvl;
  assign glitch_o = inc_o & cw_q;
  assign lvl_q_o  = lvl_q;

endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int CNT_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                inc_i,
  input  logic                glitch_i,
  input  logic                cnt_we_i,
  input  logic                mod_we_i,
  input  logic [CNT_W-1:0]    wdata_i,
  output logic [CNT_W-1:0]    cnt_o,
  output logic [CNT_W-1:0]    mod_o,
  output logic                irq_o,
  output tmr_pkg::rl_state_e  st_o
);
  import tmr_pkg::*;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] mod_q, mod_d;
  rl_state_e        st_q, st_d;
  logic             nodly_q, nodly_d;
  logic             pend_q, pend_d;
  logic             irq_q, irq_d;
  logic             fire_now;

  always_comb begin
    cnt_d   = cnt_q;
    mod_d   = mod_q;
    nodly_d = nodly_q;
    case (st_q)
      RL_LOADING: st_d = RL_DONE;
      RL_DONE:    st_d = RL_IDLE;
      default:    st_d = RL_IDLE;
    endcase
    fire_now = (st_q == RL_LOADING) &&  nodly_q;
    pend_d   = (st_q == RL_LOADING) && !nodly_q;
    irq_d    = fire_now | pend_q;

    if (cnt_we_i) begin
      cnt_d = wdata_i;
    end else if (inc_i) begin
      if (cnt_q == {CNT_W{1'b1}}) begin
        cnt_d   = mod_q;
        st_d    = RL_LOADING;
        nodly_d = glitch_i;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end

    if (mod_we_i) mod_d = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      mod_q   <= '0;
      st_q    <= RL_IDLE;
      nodly_q <= 1'b0;
      pend_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      mod_q   <= mod_d;
      st_q    <= st_d;
      nodly_q <= nodly_d;
      pend_q  <= pend_d;
      irq_q   <= irq_d;
    end
  end

  assign cnt_o = cnt_q;
  assign mod_o = mod_q;
  assign irq_o = irq_q;
  assign st_o  = st_q;

endmodule

// File: rtl/prog_timer.sv
module prog_timer #(
  parameter int DIV_W = 16,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    bus_addr,
  input  logic          bus_we,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq_o
);
  import tmr_pkg::*;

  localparam int CTRL_W = 3;
  localparam int SYNC_N = 2;

  logic [SYNC_N-1:0] rst_sync_q;
  logic              rst_n_s;

  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic              wr_div, wr_cnt, wr_mod, wr_ctrl;
  logic [DIV_W-1:0]  div_val;
  logic [DW-1:0]     cnt_val, mod_val;
  logic              inc, glitch, lvl_q;
  rl_state_e         rl_st;

  // Reset: asserted asynchronously, released after SYNC_N edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_N-2:0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[SYNC_N-1];

  always_comb begin
    wr_div  = bus_we && (bus_addr == A_DIV);
    wr_cnt  = bus_we && (bus_addr == A_CNT);
    wr_mod  = bus_we && (bus_addr == A_MOD);
    wr_ctrl = bus_we && (bus_addr == A_CTRL);
    ctrl_d  = wr_ctrl ? bus_wdata[CTRL_W-1:0] : ctrl_q;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) ctrl_q <= '0;
    else          ctrl_q <= ctrl_d;
  end

  tmr_divider #(.DIV_W(DIV_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n_s),
    .clr_i (wr_div),
    .div_o (div_val)
  );

  tmr_edge #(.DIV_W(DIV_W)) u_edge (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .div_i     (div_val),
    .en_i      (ctrl_q[2]),
    .rate_i    (ctrl_q[1:0]),
    .ctrl_wr_i (wr_ctrl),
    .inc_o     (inc),
    .glitch_o  (glitch),
    .lvl_q_o   (lvl_q)
  );

  tmr_core #(.CNT_W(DW)) u_core (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .inc_i    (inc),
    .glitch_i (glitch),
    .cnt_we_i (wr_cnt),
    .mod_we_i (wr_mod),
    .wdata_i  (bus_wdata),
    .cnt_o    (cnt_val),
    .mod_o    (mod_val),
    .irq_o    (irq_o),
    .st_o     (rl_st)
  );

  always_comb begin
    case (bus_addr)
      A_DIV:   bus_rdata = div_val[DIV_W-1 -: DW];
      A_CNT:   bus_rdata = cnt_val;
      A_MOD:   bus_rdata = mod_val;
      default: bus_rdata = {{(DW-CTRL_W){1'b1}}, ctrl_q};
    endcase
  end

endmodule

// File: rtl/prog_timer_chk.sv
module prog_timer_chk #(
  parameter int DIV_W = 16,
  parameter int DW    = 8
) (
  input logic               clk,
  input logic               rst_n_s,
  input logic [1:0]         bus_addr,
  input logic               bus_we,
  input logic [DW-1:0]      bus_rdata,
  input logic               irq_o,
  input logic [DIV_W-1:0]   div_val,
  input logic [DW-1:0]      cnt_val,
  input logic [DW-1:0]      mod_val,
  input logic               lvl_q,
  input logic               inc,
  input tmr_pkg::rl_state_e rl_st
);
  import tmr_pkg::*;

  p_ctrl_pad_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    (bus_addr == A_CTRL) |-> (bus_rdata[DW-1:3] == '1));

  p_div_clear_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (bus_we && bus_addr == A_DIV) |=> (div_val == '0));

  p_div_run_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(bus_we && bus_addr == A_DIV) |=> (div_val == $past(div_val) + 1'b1));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!lvl_q && !(bus_we && bus_addr == A_CNT)) |=> $stable(cnt_val));

  p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (inc && cnt_val == '1 && !(bus_we && bus_addr == A_CNT))
      |=> (cnt_val == $past(mod_val) && rl_st == RL_LOADING));

  p_irq_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    irq_o |=> !irq_o);

  p_irq_src_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(irq_o) |-> ($past(rl_st) == RL_LOADING || $past(rl_st, 2) == RL_LOADING));

endmodule

bind prog_timer prog_timer_chk #(.DIV_W(DIV_W), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n_s   (rst_n_s),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_rdata (bus_rdata),
  .irq_o     (irq_o),
  .div_val   (div_val),
  .cnt_val   (cnt_val),
  .mod_val   (mod_val),
  .lvl_q     (lvl_q),
  .inc       (inc),
  .rl_st     (rl_st)
);

// File: tb/prog_timer_test.sv
module prog_timer_test;

  localparam int CLK_PERIOD = 10;
  localparam int N_VEC      = 6;

  // {addr[1:0], write data[7:0], expected read[7:0]}
  localparam logic [17:0] VEC [N_VEC] = '{
    {2'd2, 8'h3C, 8'h3C},
    {2'd2, 8'hA5, 8'hA5},
    {2'd1, 8'h7E, 8'h7E},
    {2'd1, 8'h01, 8'h01},
    {2'd3, 8'h03, 8'hFB},
    {2'd3, 8'h00, 8'hF8}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] bus_addr;
  logic       bus_we;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       irq_o;

  int checks = 0;
  int errors = 0;
  int n      = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prog_timer uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h (n=%0d)", tag, got, exp, n);
    end
  endtask

  task automatic step();
    @(negedge clk);
    n++;
  endtask

  task automatic go_to(input int target);
    while (n < target) step();
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_we    = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    n++;
    if (a == 2'd0) n = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  // Leaves the divider cleared one edge ago (n=1) with the counter set
  task automatic prep(input logic [7:0] ctrl, input logic [7:0] cnt);
    wr(2'd3, 8'h00);
    wr(2'd1, 8'h00);
    wr(2'd3, ctrl);
    wr(2'd0, 8'h00);
    wr(2'd1, cnt);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    rst_n = 1'b0; bus_addr = 2'd0; bus_we = 1'b0; bus_wdata = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(2'd1, v); chk("R1 counter", v, 8'h00);
    rd(2'd2, v); chk("R1 modulo", v, 8'h00);
    rd(2'd3, v); chk("R1 control", v, 8'hF8);
    rd(2'd0, v); chk("R1 divider", v, 8'h00);
    chk("R1 irq", {7'd0, irq_o}, 8'h00);

    // R2 register table
    for (int i = 0; i < N_VEC; i++) begin
      wr(VEC[i][17:16], VEC[i][15:8]);
      rd(VEC[i][17:16], v);
      chk("R2 readback", v, VEC[i][7:0]);
    end

    // R3 divider clear and count
    prep(8'h00, 8'h00);
    go_to(255); rd(2'd0, v); chk("R3 div hi before 256", v, 8'h00);
    go_to(256); rd(2'd0, v); chk("R3 div hi at 256", v, 8'h01);

    // R4 rate 01 counting, period 16
    prep(8'h05, 8'h20);
    go_to(16); rd(2'd1, v); chk("R4 rate01 before", v, 8'h20);
    go_to(17); rd(2'd1, v); chk("R4 rate01 first", v, 8'h21);
    go_to(48); rd(2'd1, v); chk("R4 rate01 hold", v, 8'h22);
    go_to(49); rd(2'd1, v); chk("R4 rate01 third", v, 8'h23);

    // R4 rate 10, period 64
    prep(8'h06, 8'h00);
    go_to(64); rd(2'd1, v); chk("R4 rate10 before", v, 8'h00);
    go_to(65); rd(2'd1, v); chk("R4 rate10 edge", v, 8'h01);

    // R4 rate 00, period 1024
    prep(8'h04, 8'h00);
    go_to(1024); rd(2'd1, v); chk("R4 rate00 before", v, 8'h00);
    go_to(1025); rd(2'd1, v); chk("R4 rate00 edge", v, 8'h01);

    // R7 tap switch 01 -> 11 while new tap low, then R4 rate 11
    prep(8'h05, 8'h10);
    go_to(10); wr(2'd3, 8'h07);
    go_to(12); rd(2'd1, v); chk("R7 tap switch increment", v, 8'h11);
    go_to(256); rd(2'd1, v); chk("R4 rate11 before", v, 8'h11);
    go_to(257); rd(2'd1, v); chk("R4 rate11 edge", v, 8'h12);

    // R7 disable while gated tap low: no increment
    prep(8'h05, 8'h44);
    go_to(2); wr(2'd3, 8'h00);
    go_to(6); rd(2'd1, v); chk("R7 disable while low", v, 8'h44);

    // R5 R6 normal overflow
    wr(2'd2, 8'h40);
    prep(8'h05, 8'hFF);
    go_to(16); rd(2'd1, v); chk("R5 before wrap", v, 8'hFF);
    go_to(17); rd(2'd1, v); chk("R5 reload value", v, 8'h40);
    chk("R6 irq not yet", {7'd0, irq_o}, 8'h00);
    go_to(18); chk("R6 irq one cycle after", {7'd0, irq_o}, 8'h00);
    go_to(19); chk("R6 irq two cycles after", {7'd0, irq_o}, 8'h01);
    go_to(20); chk("R6 irq single cycle", {7'd0, irq_o}, 8'h00);

    // R8 control-write overflow (disable during tap high)
    wr(2'd2, 8'h80);
    prep(8'h05, 8'hFF);
    go_to(10); wr(2'd3, 8'h00);
    go_to(12); rd(2'd1, v); chk("R8 R7 reload from write", v, 8'h80);
    chk("R8 irq not yet", {7'd0, irq_o}, 8'h00);
    go_to(13); chk("R8 irq early", {7'd0, irq_o}, 8'h01);
    go_to(14); chk("R8 irq single cycle", {7'd0, irq_o}, 8'h00);

    // R9 divider clear overflow uses normal timing afterwards
    wr(2'd2, 8'h33);
    prep(8'h05, 8'hFF);
    go_to(12); wr(2'd0, 8'h5A);
    go_to(1); rd(2'd1, v); chk("R9 div clear reload", v, 8'h33);
    go_to(2); chk("R9 irq not early", {7'd0, irq_o}, 8'h00);
    go_to(3); chk("R9 irq delayed", {7'd0, irq_o}, 8'h01);

    // R9 divider clear without overflow
    prep(8'h05, 8'h50);
    go_to(12); wr(2'd0, 8'h00);
    go_to(1); rd(2'd1, v); chk("R9 div clear increment", v, 8'h51);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule